// File: doc/BRIEF.md
# UART Host Register Bank

This block is the processor-facing register file of a single UART channel. The host reaches it through a 3-bit address, a chip select, separate read and write strobes and an 8-bit data bus. Each access is decoded onto the channel's control, status, scratchpad and divisor storage. Twelve registers sit behind eight addresses, so one address can reach different storage depending on two things: whether the access is a read or a write, and the state of the divisor-bank select bit in the line-control register.

The block holds the stored control fields and presents them as outputs to the rest of the channel. It returns the interrupt-status, line-status, modem-status and received-byte values, which other logic supplies as inputs. A write to the transmit data location produces a one-cycle load strobe and the byte that goes with it. A read of the receive data location produces a one-cycle pop strobe. FIFO-control writes produce a latched enable, a latched receive trigger select and one-cycle FIFO flush pulses.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, the interrupt-enable, line-control, modem-control and scratchpad registers read 0. The 16-bit divisor reads 1. The FIFO enable and trigger select are 0. All strobes are low and the read data is 0.
- R2: With line-control bit 7 clear, a write to address 1, 3, 4 or 7 stores the byte in the interrupt-enable, line-control, modem-control or scratchpad register. A read of the same address returns the stored byte unchanged.
- R3: Read data is registered. It appears on the cycle after a read cycle. With line-control bit 7 clear, address 0 returns the received-byte input, address 2 returns the interrupt-status input, address 5 returns the line-status input and address 6 returns the modem-status input.
- R4: With line-control bit 7 set, addresses 0 and 1 read and write the low and high byte of the divisor. These accesses leave the interrupt-enable register unchanged. Address 3 still reaches line control in this state.
- R5: Writes to addresses 5 and 6 change no stored register and produce no strobe.
- R6: A write to address 0 with line-control bit 7 clear raises the transmit-load strobe for exactly the next cycle, with the written byte on the transmit data output. No other write raises this strobe.
- R7: A read of address 0 with line-control bit 7 clear raises the receive-pop strobe for exactly the next cycle. A read of address 0 with bit 7 set does not raise it.
- R8: A write to address 2 latches bit 0 as the FIFO enable and bits 7:6 as the receive trigger select. The FIFO-control value is never returned on a read; address 2 reads the interrupt-status input.
- R9: A write to address 2 with bit 1 set raises the receive-FIFO flush pulse for one cycle. The same write with bit 2 set raises the transmit-FIFO flush pulse for one cycle.
- R10: A strobe while chip select is low changes no register, produces no strobe and leaves the read data unchanged.
- R11: The read data output holds its value through every cycle that is not a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one access per cycle high |
| wr | input | 1 | Write strobe, one access per cycle high |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| isr_in | input | 8 | Interrupt-status value from interrupt logic |
| lsr_in | input | 8 | Line-status value from line logic |
| msr_in | input | 8 | Modem-status value from modem logic |
| rx_byte_in | input | 8 | Byte at the head of the receive path |
| ier_o | output | 8 | Interrupt-enable register |
| lcr_o | output | 8 | Line-control register (bit 7 selects the divisor bank) |
| mcr_o | output | 8 | Modem-control register |
| divisor_o | output | 16 | Baud divisor, high byte above low byte |
| fifo_en_o | output | 1 | FIFO enable latched from FIFO-control bit 0 |
| rx_trig_o | output | 2 | Receive trigger select latched from FIFO-control bits 7:6 |
| tx_load_o | output | 1 | One-cycle transmit-load strobe |
| tx_data_o | output | 8 | Byte accompanying the transmit-load strobe |
| rx_pop_o | output | 1 | One-cycle receive-pop strobe |
| rx_fifo_rst_o | output | 1 | One-cycle receive FIFO flush pulse |
| tx_fifo_rst_o | output | 1 | One-cycle transmit FIFO flush pulse |

## Verification
Some properties hold on every cycle, and the assertions check those. Each strobe must trace back to a selected access of the right kind at address 0 or 2, with the bank in the right state. The transmit byte must follow the written data. Divisor writes happen only while the bank bit is set. Unselected cycles and writes to the status addresses must leave the stored state untouched. The read data must hold between reads. The bench's scenarios cover what needs history: a random mix of reads and writes that checks every read against a model of the register contents. They also cover the bank switch and its return, a FIFO-control write that is never read back, the exact width of each pulse, and the reset values.

// File: rtl/uart_host_regs_pkg.sv
package uart_host_regs_pkg;

  localparam int ADDR_W = 3;

  // address slots; the order is fixed by the host software map
  localparam logic [2:0] SLOT_DATA  = 3'd0;
  localparam logic [2:0] SLOT_IEN   = 3'd1;
  localparam logic [2:0] SLOT_FIFO  = 3'd2;
  localparam logic [2:0] SLOT_LCTL  = 3'd3;
  localparam logic [2:0] SLOT_MCTL  = 3'd4;
  localparam logic [2:0] SLOT_LSTAT = 3'd5;
  localparam logic [2:0] SLOT_MSTAT = 3'd6;
  localparam logic [2:0] SLOT_SCR   = 3'd7;

  // bit of the line-control register that swaps in the divisor bank
  localparam int BANK_BIT = 7;

  // one-hot write targets
  typedef struct packed {
    logic thr;
    logic ien;
    logic fcr;
    logic lcr;
    logic mcr;
    logic scr;
    logic div_lo;
    logic div_hi;
  } wr_sel_t;

  typedef enum logic [3:0] {
    RS_RXB  = 4'd0,
    RS_IEN  = 4'd1,
    RS_ISR  = 4'd2,
    RS_LCR  = 4'd3,
    RS_MCR  = 4'd4,
    RS_LSR  = 4'd5,
    RS_MSR  = 4'd6,
    RS_SCR  = 4'd7,
    RS_DLO  = 4'd8,
    RS_DHI  = 4'd9
  } rd_sel_e;

  // write decode: which storage a write at this address reaches
  function automatic wr_sel_t write_target(input logic [2:0] a, input logic bank);
    wr_sel_t s;
    s = '0;
    unique case (a)
      SLOT_DATA:  if (bank) s.div_lo = 1'b1; else s.thr = 1'b1;
      SLOT_IEN:   if (bank) s.div_hi = 1'b1; else s.ien = 1'b1;
      SLOT_FIFO:  s.fcr = 1'b1;
      SLOT_LCTL:  s.lcr = 1'b1;
      SLOT_MCTL:  s.mcr = 1'b1;
      SLOT_SCR:   s.scr = 1'b1;
      default:    s = '0;   // status slots are read-only
    endcase
    return s;
  endfunction

  // read decode: which source a read at this address returns
  function automatic rd_sel_e read_source(input logic [2:0] a, input logic bank);
    rd_sel_e r;
    unique case (a)
      SLOT_DATA:  r = bank ? RS_DLO : RS_RXB;
      SLOT_IEN:   r = bank ? RS_DHI : RS_IEN;
      SLOT_FIFO:  r = RS_ISR;
      SLOT_LCTL:  r = RS_LCR;
      SLOT_MCTL:  r = RS_MCR;
      SLOT_LSTAT: r = RS_LSR;
      SLOT_MSTAT: r = RS_MSR;
      default:    r = RS_SCR;
    endcase
    return r;
  endfunction

  // FIFO-control field helpers
  function automatic logic fcr_enable(input logic [7:0] d);
    return d[0];
  endfunction

  function automatic logic [1:0] fcr_trigger(input logic [7:0] d);
    return d[7:6];
  endfunction

  function automatic logic fcr_rx_flush(input logic [7:0] d);
    return d[1];
  endfunction

  function automatic logic fcr_tx_flush(input logic [7:0] d);
    return d[2];
  endfunction

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_host_regs_pkg::*;
(
  input  logic                   cs,
  input  logic                   rd,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   bank,
  output wr_sel_t                wsel,
  output logic                   rd_en,
  output rd_sel_e                rsel
);

  logic wr_en;

  assign wr_en = cs & wr;
  assign rd_en = cs & rd;

  always_comb begin
    wsel = '0;
    if (wr_en) wsel = write_target(addr, bank);
  end

  assign rsel = read_source(addr, bank);

endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_host_regs_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DIV_RST = 1,
  localparam int DIV_W  = 2 * DW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_sel_t           wsel,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     ier_q,
  output logic [DW-1:0]     lcr_q,
  output logic [DW-1:0]     mcr_q,
  output logic [DW-1:0]     scr_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              fifo_en_q,
  output logic [1:0]        rx_trig_q,
  output logic              tx_load_q,
  output logic [DW-1:0]     tx_data_q,
  output logic              rx_flush_q,
  output logic              tx_flush_q
);

  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

  // plain byte registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
    end else begin
      if (wsel.ien) ier_q <= wdata;
      if (wsel.lcr) lcr_q <= wdata;
      if (wsel.mcr) mcr_q <= wdata;
      if (wsel.scr) scr_q <= wdata;
    end
  end

  // divisor bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_INIT;
    end else begin
      if (wsel.div_lo) div_q[DW-1:0]     <= wdata;
      if (wsel.div_hi) div_q[DIV_W-1:DW] <= wdata;
    end
  end

  // FIFO control: fields latched, flush bits pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q  <= 1'b0;
      rx_trig_q  <= 2'b00;
      rx_flush_q <= 1'b0;
      tx_flush_q <= 1'b0;
    end else begin
      rx_flush_q <= wsel.fcr & fcr_rx_flush(wdata[7:0]);
      tx_flush_q <= wsel.fcr & fcr_tx_flush(wdata[7:0]);
      if (wsel.fcr) begin
        fifo_en_q <= fcr_enable(wdata[7:0]);
        rx_trig_q <= fcr_trigger(wdata[7:0]);
      end
    end
  end

  // transmit load strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_load_q <= 1'b0;
      tx_data_q <= '0;
    end else begin
      tx_load_q <= wsel.thr;
      if (wsel.thr) tx_data_q <= wdata;
    end
  end

  AST_DIV_NEEDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel.div_lo | wsel.div_hi) |-> lcr_q[BANK_BIT]); // R4

  AST_THR_NEEDS_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.thr |-> !lcr_q[BANK_BIT]); // R6

  AST_WSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel)); // R2

endmodule

// File: rtl/uart_read_path.sv
module uart_read_path
  import uart_host_regs_pkg::*;
#(
  parameter int DW     = 8,
  localparam int DIV_W = 2 * DW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  rd_sel_e           rsel,
  input  logic [DW-1:0]     rx_byte,
  input  logic [DW-1:0]     isr_v,
  input  logic [DW-1:0]     lsr_v,
  input  logic [DW-1:0]     msr_v,
  input  logic [DW-1:0]     ier_v,
  input  logic [DW-1:0]     lcr_v,
  input  logic [DW-1:0]     mcr_v,
  input  logic [DW-1:0]     scr_v,
  input  logic [DIV_W-1:0]  div_v,
  output logic [DW-1:0]     rdata_q,
  output logic              rx_pop_q
);

  logic [DW-1:0] rd_mux;

  always_comb begin
    unique case (rsel)
      RS_RXB:  rd_mux = rx_byte;
      RS_IEN:  rd_mux = ier_v;
      RS_ISR:  rd_mux = isr_v;
      RS_LCR:  rd_mux = lcr_v;
      RS_MCR:  rd_mux = mcr_v;
      RS_LSR:  rd_mux = lsr_v;
      RS_MSR:  rd_mux = msr_v;
      RS_SCR:  rd_mux = scr_v;
      RS_DLO:  rd_mux = div_v[DW-1:0];
      RS_DHI:  rd_mux = div_v[DIV_W-1:DW];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rx_pop_q <= 1'b0;
    end else begin
      rx_pop_q <= rd_en && (rsel == RS_RXB);
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q)); // R11

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        rd,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  isr_in,
  input  logic [7:0]  lsr_in,
  input  logic [7:0]  msr_in,
  input  logic [7:0]  rx_byte_in,
  output logic [7:0]  ier_o,
  output logic [7:0]  lcr_o,
  output logic [7:0]  mcr_o,
  output logic [15:0] divisor_o,
  output logic        fifo_en_o,
  output logic [1:0]  rx_trig_o,
  output logic        tx_load_o,
  output logic [7:0]  tx_data_o,
  output logic        rx_pop_o,
  output logic        rx_fifo_rst_o,
  output logic        tx_fifo_rst_o
);

  localparam int DW = 8;

  wr_sel_t    wsel;
  rd_sel_e    rsel;
  logic       rd_en;
  logic [7:0] scr_q;

  // named events for the assertions below
  logic acc_thr_wr;
  logic acc_rxb_rd;
  logic acc_fcr_wr;
  logic acc_stat_wr;
  logic bank_on;

  assign bank_on     = lcr_o[BANK_BIT];
  assign acc_thr_wr  = cs && wr && (addr == SLOT_DATA) && !bank_on;
  assign acc_rxb_rd  = cs && rd && (addr == SLOT_DATA) && !bank_on;
  assign acc_fcr_wr  = cs && wr && (addr == SLOT_FIFO);
  assign acc_stat_wr = cs && wr && (addr == SLOT_LSTAT || addr == SLOT_MSTAT);

  uart_reg_decode u_dec (
    .cs    (cs),
    .rd    (rd),
    .wr    (wr),
    .addr  (addr),
    .bank  (bank_on),
    .wsel  (wsel),
    .rd_en (rd_en),
    .rsel  (rsel)
  );

  uart_ctrl_regs #(.DW(DW), .DIV_RST(1)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wsel       (wsel),
    .wdata      (wdata),
    .ier_q      (ier_o),
    .lcr_q      (lcr_o),
    .mcr_q      (mcr_o),
    .scr_q      (scr_q),
    .div_q      (divisor_o),
    .fifo_en_q  (fifo_en_o),
    .rx_trig_q  (rx_trig_o),
    .tx_load_q  (tx_load_o),
    .tx_data_q  (tx_data_o),
    .rx_flush_q (rx_fifo_rst_o),
    .tx_flush_q (tx_fifo_rst_o)
  );

  uart_read_path #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rsel     (rsel),
    .rx_byte  (rx_byte_in),
    .isr_v    (isr_in),
    .lsr_v    (lsr_in),
    .msr_v    (msr_in),
    .ier_v    (ier_o),
    .lcr_v    (lcr_o),
    .mcr_v    (mcr_o),
    .scr_v    (scr_q),
    .div_v    (divisor_o),
    .rdata_q  (rdata),
    .rx_pop_q (rx_pop_o)
  );

  AST_TX_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |-> $past(acc_thr_wr)); // R6

  AST_TX_DATA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    acc_thr_wr |=> (tx_load_o && tx_data_o == $past(wdata))); // R6

  AST_RX_POP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_o |-> $past(acc_rxb_rd)); // R7

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_rst_o || tx_fifo_rst_o) |-> $past(acc_fcr_wr)); // R9

  AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stat_wr |=> ($stable(ier_o) && $stable(lcr_o) && $stable(mcr_o)
                     && $stable(divisor_o) && !tx_load_o)); // R5

  AST_UNSELECTED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> ($stable(ier_o) && $stable(lcr_o) && $stable(mcr_o) && $stable(divisor_o)
             && $stable(rdata) && !tx_load_o && !rx_pop_o && !rx_fifo_rst_o)); // R10

endmodule

// File: tb/uart_host_regs_tb.sv
module uart_host_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  isr_in = '0, lsr_in = '0, msr_in = '0, rx_byte_in = '0;
  logic [7:0]  rdata, ier_o, lcr_o, mcr_o, tx_data_o;
  logic [15:0] divisor_o;
  logic        fifo_en_o, tx_load_o, rx_pop_o, rx_fifo_rst_o, tx_fifo_rst_o;
  logic [1:0]  rx_trig_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  uart_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .isr_in(isr_in), .lsr_in(lsr_in),
    .msr_in(msr_in), .rx_byte_in(rx_byte_in), .ier_o(ier_o), .lcr_o(lcr_o),
    .mcr_o(mcr_o), .divisor_o(divisor_o), .fifo_en_o(fifo_en_o),
    .rx_trig_o(rx_trig_o), .tx_load_o(tx_load_o), .tx_data_o(tx_data_o),
    .rx_pop_o(rx_pop_o), .rx_fifo_rst_o(rx_fifo_rst_o), .tx_fifo_rst_o(tx_fifo_rst_o)
  );

  // reference model state
  logic [7:0]  m_ier, m_lcr, m_mcr, m_scr, m_dll, m_dlm, m_rdata;
  logic        m_fen;
  logic [1:0]  m_trig;

  // observations taken one cycle after an access, and one cycle later
  logic [7:0]  o_rdata, o_txd;
  logic        o_txl, o_pop, o_rxf, o_txf;
  logic        p_txl, p_pop, p_rxf, p_txf;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    if (m_lcr[7] && a == 3'd0) return m_dll;
    if (m_lcr[7] && a == 3'd1) return m_dlm;
    case (a)
      3'd0: return rx_byte_in;
      3'd1: return m_ier;
      3'd2: return isr_in;
      3'd3: return m_lcr;
      3'd4: return m_mcr;
      3'd5: return lsr_in;
      3'd6: return msr_in;
      default: return m_scr;
    endcase
  endfunction

  function automatic bit exp_txload(input logic [2:0] a);
    return (a == 3'd0) && !m_lcr[7];
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    if (m_lcr[7] && a == 3'd0) m_dll = d;
    else if (m_lcr[7] && a == 3'd1) m_dlm = d;
    else case (a)
      3'd1: m_ier = d;
      3'd2: begin m_fen = d[0]; m_trig = d[7:6]; end
      3'd3: m_lcr = d;
      3'd4: m_mcr = d;
      3'd7: m_scr = d;
      default: ;
    endcase
  endtask

  // one access cycle, then two observation points
  task automatic access(input bit c, input bit w, input bit r,
                        input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = c; wr = w; rd = r; addr = a; wdata = d;
    @(negedge clk);
    o_rdata = rdata; o_txl = tx_load_o; o_txd = tx_data_o;
    o_pop = rx_pop_o; o_rxf = rx_fifo_rst_o; o_txf = tx_fifo_rst_o;
    cs = 1'b0; wr = 1'b0; rd = 1'b0;
    @(negedge clk);
    p_txl = tx_load_o; p_pop = rx_pop_o; p_rxf = rx_fifo_rst_o; p_txf = tx_fifo_rst_o;
  endtask

  // checked write / read against the model
  task automatic do_write(input bit c, input logic [2:0] a, input logic [7:0] d, input string req);
    bit etx, erf, etf;
    etx = c && exp_txload(a);
    erf = c && a == 3'd2 && d[1];
    etf = c && a == 3'd2 && d[2];
    access(c, 1'b1, 1'b0, a, d);
    if (c) model_write(a, d);
    chk({req, " tx_load"}, o_txl, etx);
    if (etx) chk({req, " R6 tx_data"}, o_txd, d);
    chk({req, " R9 rx flush"}, o_rxf, erf);
    chk({req, " R9 tx flush"}, o_txf, etf);
    chk({req, " R10 no pop"}, o_pop, 0);
    chk({req, " R6 R9 one-cycle"}, {p_txl, p_rxf, p_txf}, 0);
    chk({req, " R11 rdata held"}, o_rdata, m_rdata);
  endtask

  task automatic do_read(input bit c, input logic [2:0] a, input string req);
    logic [7:0] e;
    bit epop;
    e = c ? exp_read(a) : m_rdata;
    epop = c && exp_txload(a);
    access(c, 1'b0, 1'b1, a, 8'h00);
    m_rdata = e;
    chk({req, " rdata"}, o_rdata, e);
    chk({req, " R7 rx_pop"}, o_pop, epop);
    chk({req, " R7 pop one-cycle"}, p_pop, 0);
    chk({req, " R10 no tx_load"}, o_txl, 0);
  endtask

  task automatic chk_outputs(input string req);
    chk({req, " ier"}, ier_o, m_ier);
    chk({req, " lcr"}, lcr_o, m_lcr);
    chk({req, " mcr"}, mcr_o, m_mcr);
    chk({req, " divisor"}, divisor_o, {m_dlm, m_dll});
    chk({req, " R8 fifo_en"}, fifo_en_o, m_fen);
    chk({req, " R8 trig"}, rx_trig_o, m_trig);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    m_ier = 0; m_lcr = 0; m_mcr = 0; m_scr = 0; m_dll = 8'h01; m_dlm = 0;
    m_fen = 0; m_trig = 0; m_rdata = 0;

    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk("R1 rdata", rdata, 0);
    chk("R1 strobes", {tx_load_o, rx_pop_o, rx_fifo_rst_o, tx_fifo_rst_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outputs("R1");
    do_read(1, 3'd7, "R1 scratch");

    // R2 plain registers
    do_write(1, 3'd1, 8'hA5, "R2 ien");
    do_write(1, 3'd4, 8'h1B, "R2 mcr");
    do_write(1, 3'd7, 8'h3C, "R2 scr");
    do_write(1, 3'd3, 8'h03, "R2 lcr");
    do_read(1, 3'd1, "R2 ien");
    do_read(1, 3'd4, "R2 mcr");
    do_read(1, 3'd7, "R2 scr");
    do_read(1, 3'd3, "R2 lcr");

    // R3 status sources
    isr_in = 8'hC1; lsr_in = 8'h60; msr_in = 8'hB0; rx_byte_in = 8'h77;
    do_read(1, 3'd2, "R3 isr R8");
    do_read(1, 3'd5, "R3 lsr");
    do_read(1, 3'd6, "R3 msr");
    do_read(1, 3'd0, "R3 R7 rx byte");

    // R4 divisor bank
    do_write(1, 3'd3, 8'h83, "R4 bank on");
    do_write(1, 3'd0, 8'h34, "R4 dll");
    do_write(1, 3'd1, 8'h12, "R4 dlm");
    chk("R4 divisor", divisor_o, 16'h1234);
    chk("R4 ien untouched", ier_o, 8'hA5);
    do_read(1, 3'd0, "R4 R7 dll no pop");
    do_read(1, 3'd1, "R4 dlm");
    do_read(1, 3'd3, "R4 lcr in bank");
    do_write(1, 3'd3, 8'h03, "R4 bank off");
    do_read(1, 3'd1, "R4 ien after bank");

    // R5 read-only slots
    do_write(1, 3'd5, 8'hFF, "R5 lsr wr");
    do_write(1, 3'd6, 8'hFF, "R5 msr wr");
    chk_outputs("R5");
    do_read(1, 3'd7, "R5 scr");

    // R6 transmit strobe
    do_write(1, 3'd0, 8'h5A, "R6 thr");

    // R8 R9 FIFO control
    do_write(1, 3'd2, 8'hC7, "R8 R9 fcr");
    chk_outputs("R8 fcr fields");
    do_read(1, 3'd2, "R8 no fcr readback");
    do_write(1, 3'd2, 8'h41, "R8 fcr 2");
    chk_outputs("R8 fcr fields 2");

    // R10 unselected
    do_write(0, 3'd1, 8'h00, "R10 wr nocs");
    do_write(0, 3'd0, 8'h99, "R10 thr nocs");
    do_read(0, 3'd0, "R10 R11 rd nocs");
    chk_outputs("R10");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      bit c, w;
      isr_in = 8'($urandom); lsr_in = 8'($urandom);
      msr_in = 8'($urandom); rx_byte_in = 8'($urandom);
      a = 3'($urandom);
      d = 8'($urandom);
      if (a == 3'd3) d[7] = ($urandom % 4) == 0;
      c = ($urandom % 10) != 0;
      w = ($urandom % 2) == 0;
      if (w) do_write(c, a, d, "R2 R4 R6 rand wr");
      else   do_read(c, a, "R3 R4 R7 rand rd");
      chk_outputs("R2 R4 R5 rand");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule